// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number plus an offset, into a physical address. It holds a small on-chip table with one entry per segment. Each entry records where the segment starts in physical memory, how long it is, whether it is in use, and whether it may be read, written or executed. A separate length register sets how many segments count as legal. Software fills the table and the length register through a simple write port. The access path then applies four checks in a fixed order. It either emits the start address plus the offset, or it raises a trap that carries one cause code.

A request is captured on the clock edge where `req_valid` is high. The answer is formed combinationally from that captured request and appears on the response outputs during the following cycle. The four checks are, in priority order: segment number against length, entry in use, offset against segment length, and access privilege. Only the highest-priority failure is reported.

Top module: `segxlate_unit`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after an edge at which `req_valid` was high, and low otherwise.
- R2: A legal access returns `rsp_trap`=0, `rsp_cause`=0 and `rsp_addr` = (entry base + offset) modulo 2^PA_W.
- R3: A segment number greater than or equal to the length register traps with cause 1. This check outranks all others. The length register is SEG_W+1 bits wide and is loaded by `len_we`/`len_val`.
- R4: A segment whose in-use bit is 0 traps with cause 2. This check outranks the limit and privilege checks.
- R5: An offset greater than or equal to the entry's segment length traps with cause 3. This check outranks the privilege check.
- R6: An access without its privilege traps with cause 4. Access kind 0 (read) needs permission bit 0, kind 1 (write) needs bit 1, and kind 2 (execute) needs bit 2. Kind 3 always traps with cause 4.
- R7: Whenever `rsp_trap` is high, `rsp_addr` is 0 and `rsp_cause` is nonzero. Whenever `rsp_trap` is low, `rsp_cause` is 0.
- R8: Reset clears the length register and every in-use bit, so any request that follows reset traps with cause 1.
- R9: When `cfg_we` is high at an edge, it replaces the entry at `cfg_idx` with base, segment length, in-use bit and permissions. Every request captured after that edge sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | SEG_W | Entry to write |
| cfg_base | input | PA_W | Physical start address |
| cfg_limit | input | OFS_W+1 | Segment length |
| cfg_valid | input | 1 | Entry in-use bit |
| cfg_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| len_we | input | 1 | Length register write strobe |
| len_val | input | SEG_W+1 | New number of legal segments |
| req_valid | input | 1 | Request strobe |
| req_seg | input | SEG_W | Segment number |
| req_ofs | input | OFS_W | Offset within segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Access refused |
| rsp_cause | output | 3 | 0 none, 1 length, 2 not in use, 3 limit, 4 privilege |
| rsp_addr | output | PA_W | Physical address, 0 on trap |

## Verification
The hardest situation to reach is a request that breaks several rules at once, because only the top-priority cause may show. To build it, the stimulus configures entries that fail more than one check. One entry is not in use and is also hit with a large offset. Another is read-only and is hit by a write past its end. A third lies just beyond the length register. The stimulus also extends the length register later, so that a once-illegal segment becomes legal, and it uses an entry whose base sits near the top of the address space so that the sum wraps.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_LEN     = 3'd1,
      CAUSE_INVALID = 3'd2,
      CAUSE_LIMIT   = 3'd3,
      CAUSE_PERM    = 3'd4
   } cause_t;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_t;

   localparam int PERM_W   = 3;
   localparam int PERM_RD  = 0;
   localparam int PERM_WR  = 1;
   localparam int PERM_EX  = 2;
endpackage

// File: rtl/segxlate_table.sv
module segxlate_table #(
   parameter int SEG_W = 3,
   parameter int PA_W  = 16,
   parameter int LIM_W = 13
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [SEG_W-1:0]              wr_idx,
   input  logic [PA_W-1:0]               wr_base,
   input  logic [LIM_W-1:0]              wr_limit,
   input  logic                          wr_valid,
   input  logic [segxlate_pkg::PERM_W-1:0] wr_perm,
   input  logic [SEG_W-1:0]              rd_idx,
   output logic [PA_W-1:0]               rd_base,
   output logic [LIM_W-1:0]              rd_limit,
   output logic                          rd_valid,
   output logic [segxlate_pkg::PERM_W-1:0] rd_perm,
   output logic [(1<<SEG_W)-1:0]         valid_vec
);
   localparam int NENT = 1 << SEG_W;

   logic [PA_W-1:0]                  base_a  [NENT];
   logic [LIM_W-1:0]                 limit_a [NENT];
   logic [segxlate_pkg::PERM_W-1:0]  perm_a  [NENT];

   for (genvar e = 0; e < NENT; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_a[e]    <= '0;
            limit_a[e]   <= '0;
            perm_a[e]    <= '0;
            valid_vec[e] <= 1'b0;
         end else if (wr_en && (wr_idx == SEG_W'(e))) begin
            base_a[e]    <= wr_base;
            limit_a[e]   <= wr_limit;
            perm_a[e]    <= wr_perm;
            valid_vec[e] <= wr_valid;
         end
      end
   end

   assign rd_base  = base_a[rd_idx];
   assign rd_limit = limit_a[rd_idx];
   assign rd_perm  = perm_a[rd_idx];
   assign rd_valid = valid_vec[rd_idx];
endmodule

// File: rtl/segxlate_rules.sv
module segxlate_rules #(
   parameter int SEG_W = 3,
   parameter int OFS_W = 12,
   parameter int LIM_W = 13
) (
   input  logic [SEG_W-1:0]                seg,
   input  logic [SEG_W:0]                  seg_count,
   input  logic                            ent_valid,
   input  logic [OFS_W-1:0]                ofs,
   input  logic [LIM_W-1:0]                limit,
   input  logic [segxlate_pkg::PERM_W-1:0] perm,
   input  logic [1:0]                      kind,
   output segxlate_pkg::cause_t            cause
);
   import segxlate_pkg::*;

   logic priv_ok;

   always_comb begin
      case (acc_t'(kind))
         ACC_READ:  priv_ok = perm[PERM_RD];
         ACC_WRITE: priv_ok = perm[PERM_WR];
         ACC_EXEC:  priv_ok = perm[PERM_EX];
         default:   priv_ok = 1'b0;
      endcase
   end

   always_comb begin
      if ({1'b0, seg} >= seg_count)
         cause = CAUSE_LEN;
      else if (!ent_valid)
         cause = CAUSE_INVALID;
      else if (LIM_W'(ofs) >= limit)
         cause = CAUSE_LIMIT;
      else if (!priv_ok)
         cause = CAUSE_PERM;
      else
         cause = CAUSE_NONE;
   end
endmodule

// File: rtl/segxlate_unit.sv
module segxlate_unit #(
   parameter int SEG_W = 3,
   parameter int OFS_W = 12,
   parameter int PA_W  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SEG_W-1:0]     cfg_idx,
   input  logic [PA_W-1:0]      cfg_base,
   input  logic [OFS_W:0]       cfg_limit,
   input  logic                 cfg_valid,
   input  logic [2:0]           cfg_perm,
   input  logic                 len_we,
   input  logic [SEG_W:0]       len_val,
   input  logic                 req_valid,
   input  logic [SEG_W-1:0]     req_seg,
   input  logic [OFS_W-1:0]     req_ofs,
   input  logic [1:0]           req_kind,
   output logic                 rsp_valid,
   output logic                 rsp_trap,
   output logic [2:0]           rsp_cause,
   output logic [PA_W-1:0]      rsp_addr
);
   import segxlate_pkg::*;

   localparam int LIM_W = OFS_W + 1;
   localparam int NENT  = 1 << SEG_W;

   if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg
      $error("segxlate_unit: SEG_W out of range");
   end
   if (PA_W < OFS_W) begin : g_bad_pa
      $error("segxlate_unit: PA_W narrower than OFS_W");
   end

   logic [SEG_W:0]      len_q;
   logic                vld_q;
   logic [SEG_W-1:0]    seg_q;
   logic [OFS_W-1:0]    ofs_q;
   logic [1:0]          kind_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q  <= '0;
         vld_q  <= 1'b0;
         seg_q  <= '0;
         ofs_q  <= '0;
         kind_q <= '0;
      end else begin
         if (len_we) len_q <= len_val;
         vld_q <= req_valid;
         if (req_valid) begin
            seg_q  <= req_seg;
            ofs_q  <= req_ofs;
            kind_q <= req_kind;
         end
      end
   end

   logic [PA_W-1:0]   ent_base;
   logic [LIM_W-1:0]  ent_limit;
   logic              ent_valid;
   logic [PERM_W-1:0] ent_perm;
   logic [NENT-1:0]   valid_vec;

   segxlate_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_idx    (cfg_idx),
      .wr_base   (cfg_base),
      .wr_limit  (cfg_limit),
      .wr_valid  (cfg_valid),
      .wr_perm   (cfg_perm),
      .rd_idx    (seg_q),
      .rd_base   (ent_base),
      .rd_limit  (ent_limit),
      .rd_valid  (ent_valid),
      .rd_perm   (ent_perm),
      .valid_vec (valid_vec)
   );

   cause_t cause;

   segxlate_rules #(.SEG_W(SEG_W), .OFS_W(OFS_W), .LIM_W(LIM_W)) u_rules (
      .seg       (seg_q),
      .seg_count (len_q),
      .ent_valid (ent_valid),
      .ofs       (ofs_q),
      .limit     (ent_limit),
      .perm      (ent_perm),
      .kind      (kind_q),
      .cause     (cause)
   );

   logic [PA_W-1:0] sum;
   assign sum = ent_base + PA_W'(ofs_q);

   always_comb begin
      rsp_valid = vld_q;
      rsp_trap  = vld_q && (cause != CAUSE_NONE);
      rsp_cause = vld_q ? cause : CAUSE_NONE;
      rsp_addr  = (vld_q && cause == CAUSE_NONE) ? sum : '0;
   end
endmodule

// File: rtl/segxlate_chk.sv
module segxlate_chk #(
   parameter int SEG_W = 3,
   parameter int PA_W  = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  rsp_valid,
   input logic                  rsp_trap,
   input logic [2:0]            rsp_cause,
   input logic [PA_W-1:0]       rsp_addr,
   input logic [SEG_W-1:0]      seg_q,
   input logic [SEG_W:0]        len_q,
   input logic [(1<<SEG_W)-1:0] valid_vec
);
   assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_trap_addr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_addr == '0 && rsp_cause != 3'd0));
   assert_clean_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_trap |-> rsp_cause == 3'd0);
   assert_length_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && ({1'b0, seg_q} >= len_q)) |-> rsp_cause == 3'd1);
   assert_invalid_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && ({1'b0, seg_q} < len_q) && !valid_vec[seg_q]) |-> rsp_cause == 3'd2);
endmodule

bind segxlate_unit segxlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .rsp_valid (rsp_valid),
   .rsp_trap  (rsp_trap),
   .rsp_cause (rsp_cause),
   .rsp_addr  (rsp_addr),
   .seg_q     (seg_q),
   .len_q     (len_q),
   .valid_vec (valid_vec)
);

// File: tb/segxlate_unit_bench.sv
`timescale 1ns/1ps
module segxlate_unit_bench;
   localparam int SEG_W = 3;
   localparam int OFS_W = 12;
   localparam int PA_W  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [SEG_W-1:0] cfg_idx = '0;
   logic [PA_W-1:0]  cfg_base = '0;
   logic [OFS_W:0]   cfg_limit = '0;
   logic             cfg_valid = 1'b0;
   logic [2:0]       cfg_perm = '0;
   logic             len_we = 1'b0;
   logic [SEG_W:0]   len_val = '0;
   logic             req_valid = 1'b0;
   logic [SEG_W-1:0] req_seg = '0;
   logic [OFS_W-1:0] req_ofs = '0;
   logic [1:0]       req_kind = '0;
   logic             rsp_valid, rsp_trap;
   logic [2:0]       rsp_cause;
   logic [PA_W-1:0]  rsp_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   segxlate_unit #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_segxlate_unit (.*);

   // vector: seg(3) ofs(12) kind(2) cause(3) addr(16)
   localparam int NV = 14;
   localparam logic [35:0] VEC [NV] = '{
      {3'd0, 12'h000, 2'd0, 3'd0, 16'h1000},
      {3'd0, 12'h0FF, 2'd1, 3'd0, 16'h10FF},
      {3'd0, 12'h100, 2'd0, 3'd3, 16'h0000},
      {3'd1, 12'h010, 2'd0, 3'd0, 16'h2010},
      {3'd1, 12'h010, 2'd1, 3'd4, 16'h0000},
      {3'd1, 12'h040, 2'd1, 3'd3, 16'h0000},
      {3'd2, 12'h000, 2'd0, 3'd2, 16'h0000},
      {3'd2, 12'h500, 2'd1, 3'd2, 16'h0000},
      {3'd5, 12'h000, 2'd0, 3'd1, 16'h0000},
      {3'd7, 12'hFFF, 2'd2, 3'd1, 16'h0000},
      {3'd3, 12'h100, 2'd2, 3'd0, 16'h0080},
      {3'd3, 12'h000, 2'd0, 3'd4, 16'h0000},
      {3'd4, 12'h000, 2'd0, 3'd3, 16'h0000},
      {3'd0, 12'h010, 2'd3, 3'd4, 16'h0000}
   };

   function automatic string tag_of(input logic [2:0] c);
      case (c)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic expect_rsp(input string tag, input logic v, input logic [2:0] c,
                             input logic [PA_W-1:0] a);
      checks++;
      if (rsp_valid !== v || rsp_cause !== c || rsp_addr !== a ||
          rsp_trap !== (v && c != 3'd0)) begin
         fails++;
         $display("FAIL %s: valid=%0b trap=%0b cause=%0d addr=%h, expected valid=%0b cause=%0d addr=%h",
                  tag, rsp_valid, rsp_trap, rsp_cause, rsp_addr, v, c, a);
      end
   endtask

   task automatic set_entry(input int idx, input logic [PA_W-1:0] b, input logic [OFS_W:0] l,
                            input logic v, input logic [2:0] p);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_base = b; cfg_limit = l;
      cfg_valid = v; cfg_perm = p;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_len(input int n);
      @(negedge clk);
      len_we = 1'b1; len_val = (SEG_W+1)'(n);
      @(negedge clk);
      len_we = 1'b0;
   endtask

   // drive at a falling edge, captured at the rising edge, sampled at the next falling edge
   task automatic issue(input int s, input logic [OFS_W-1:0] o, input logic [1:0] k);
      @(negedge clk);
      req_valid = 1'b1; req_seg = SEG_W'(s); req_ofs = o; req_kind = k;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R8: outputs quiet in reset
      expect_rsp("R8 reset idle", 1'b0, 3'd0, '0);
      rst_n = 1'b1;
      // R8: length cleared by reset, so segment 0 is out of range
      issue(0, 12'h000, 2'd0);
      expect_rsp("R8 post-reset length", 1'b1, 3'd1, '0);
      // R1: no request, no response
      @(negedge clk);
      expect_rsp("R1 idle cycle", 1'b0, 3'd0, '0);

      set_entry(0, 16'h1000, 13'h100, 1'b1, 3'b111);
      set_entry(1, 16'h2000, 13'h040, 1'b1, 3'b001);
      set_entry(2, 16'h3000, 13'h100, 1'b0, 3'b111);
      set_entry(3, 16'hFF80, 13'h200, 1'b1, 3'b100);
      set_entry(4, 16'h0500, 13'h000, 1'b1, 3'b111);
      set_entry(5, 16'h6000, 13'h010, 1'b1, 3'b001);
      set_len(5);

      for (int i = 0; i < NV; i++) begin
         logic [35:0] v;
         v = VEC[i];
         issue(int'(v[35:33]), v[32:21], v[20:19]);
         expect_rsp(tag_of(v[18:16]), 1'b1, v[18:16], v[15:0]);
      end

      // R3: extending the length makes segment 5 legal; segment 6 still beyond
      set_len(6);
      issue(5, 12'h004, 2'd0);
      expect_rsp("R3 extended length", 1'b1, 3'd0, 16'h6004);
      issue(6, 12'h000, 2'd0);
      expect_rsp("R3 length boundary", 1'b1, 3'd1, '0);

      // R9: rewriting entry 1 with write permission takes effect
      set_entry(1, 16'h2000, 13'h040, 1'b1, 3'b011);
      issue(1, 12'h010, 2'd1);
      expect_rsp("R9 rewritten entry", 1'b1, 3'd0, 16'h2010);

      // R1: back-to-back requests each answered in the following cycle
      @(negedge clk);
      req_valid = 1'b1; req_seg = 3'd0; req_ofs = 12'h020; req_kind = 2'd2;
      @(negedge clk);
      expect_rsp("R1 back-to-back first", 1'b1, 3'd0, 16'h1020);
      req_seg = 3'd2; req_ofs = 12'h000; req_kind = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      expect_rsp("R1 back-to-back second", 1'b1, 3'd2, '0);
      @(negedge clk);
      expect_rsp("R1 response drops", 1'b0, 3'd0, '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule